// File: doc/BRIEF.md
# System Control Register Write Unit

This block takes software writes aimed at a bank of 32 system control registers, each 32 bits wide. A write names a 5-bit register number and a 3-bit select. For every register a fixed pair of masks decides which bits come from the write data, which bits hold their current value, and which bits always read as zero. Registers that hold no writable state are ignored. Registers that are architecturally read-only are ignored too. Writes to the cycle counter and the timer compare value are not stored here. They are sent out on a timer port as a strobe plus data.

Some writes have side effects, and these take effect on the same clock edge as the store:
- A write to the processor status register updates the user, error-level and exception-level mode flags.
- The same write raises or drops the hardware interrupt request, depending on how the interrupt-enable bit moves.
- A write to the debug register updates the debug-mode flag.
- A write to the translation entry-high register pulses a translation-flush request if the address-space identifier changes.
- A nonzero select on any register raises a reserved-instruction exception pulse, and nothing is written.

All register contents are visible on a flat output bus, so that neighbouring logic (translation, exception entry, read mux) can use them directly.

Top module: `sysreg_wr_unit`

## Requirements
- R1: Every effect of a write appears on the outputs one clock edge after the strobe. A synchronous active-high reset clears all registers, all flags and all pulses.
- R2: A write with a nonzero select raises `ri_exc_o` for one cycle and changes no register. This applies to every register, including 16 and 28, where only select 0 exists.
- R3: The following registers store the write data ANDed with a fixed mask:

  | Register | Mask |
  |---|---|
  | 0 | 0x0000000F (bit 31 holds) |
  | 2 | 0x3FFFFFFF |
  | 3 | 0x3FFFFFFF |
  | 5 | 0x01FFE000 |
  | 6 | 0x0000000F |
  | 19 | 0x40FF0FF8 |
  | 28 | 0xFFFFFCF6 |

- R4: The following registers are merged as (old & hold) | (data & take):

  | Register | Hold mask | Take mask |
  |---|---|---|
  | 4 | 0xFF800000 | 0x007FFFF0 |
  | 13 | 0xB000F87C | 0x00C00300 |
  | 16 | 0x8017FF80 | 0x7E000001 |
  | 23 | 0x8C03FC1F | 0x13300120 |

- R5: Register 10 stores the data ANDed with 0xFFFFE0FF. `tlb_flush_o` pulses for one cycle only when data[7:0] differs from the stored bits 7:0.
- R6: Register 12 stores the data ANDed with 0xFA78FF01. The flags take their values from the written data as follows:

  | Flag | Data bit |
  |---|---|
  | `user_mode_o` | 4 |
  | `err_lvl_o` | 2 |
  | `exc_lvl_o` | 1 |

- R7: `hw_irq_o` sets on a register-12 write when all of the following hold:
  - The enable bit 0 goes from 0 to 1.
  - Data bits 1 and 2 are both clear.
  - `dbg_mode_o` is clear.
  - (new register 12 & register 13 & 0x0000FF00) is nonzero.
- R8: `hw_irq_o` clears on a register-12 write that moves bit 0 from 1 to 0. Otherwise it holds its value.
- R9: `dbg_mode_o` follows bit 30 of each register-23 write.
- R10: Writes to registers 1, 7, 8, 15, 17, 20, 21, 22, 25, 26, 27 and 29 change nothing. These registers read as zero.
- R11: Registers 14, 18, 24, 30 and 31 store all 32 data bits.
- R12: A write to register 9 or 11 stores nothing. It pulses `tmr_wr_o` and presents the data on `tmr_data_o`. `tmr_is_cmp_o` is 1 for register 11 and 0 for register 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 5 | Register number |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| reg_view_o | output | 1024 | All registers; register n at bits [32n+31:32n] |
| user_mode_o | output | 1 | User-mode flag |
| exc_lvl_o | output | 1 | Exception-level flag |
| err_lvl_o | output | 1 | Error-level flag |
| dbg_mode_o | output | 1 | Debug-mode flag |
| hw_irq_o | output | 1 | Hardware interrupt request |
| tlb_flush_o | output | 1 | One-cycle translation-flush request |
| ri_exc_o | output | 1 | One-cycle reserved-instruction exception |
| tmr_wr_o | output | 1 | One-cycle timer write strobe |
| tmr_is_cmp_o | output | 1 | Timer write targets compare (1) or count (0) |
| tmr_data_o | output | 32 | Timer write data |

## Verification
The bench builds the block with its default parameters: a 5-bit register number, a 3-bit select and an 8-bit address-space identifier. With these values all 32 register slots are reachable, and so is every nonzero select on registers 16 and 28. Because the whole 8-bit identifier field is compared, a write that changes only the upper register bits can be checked for the absence of a flush. The full set of interrupt-enable transitions can also be exercised with software-pending bits 9:8 of register 13, including each of the blocking conditions.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int DW = 32;
  typedef logic [DW-1:0] word_t;

  // register slots whose number carries behaviour
  localparam int unsigned R_TLBIDX  = 0;
  localparam int unsigned R_CTXT    = 4;
  localparam int unsigned R_TICKS   = 9;
  localparam int unsigned R_VPNHI   = 10;
  localparam int unsigned R_TMATCH  = 11;
  localparam int unsigned R_PSTAT   = 12;
  localparam int unsigned R_TRAPWHY = 13;
  localparam int unsigned R_CFGA    = 16;
  localparam int unsigned R_DBGCTL  = 23;
  localparam int unsigned R_CTAG    = 28;

  // bit positions inside the status and debug words
  localparam int ST_IEN  = 0;
  localparam int ST_EXC  = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_USR  = 4;
  localparam int DB_MODE = 30;

  localparam word_t IRQ_LINE_MASK = 32'h0000_FF00;

  // bits of a slot that survive a write
  function automatic word_t hold_bits(int unsigned idx);
    case (idx)
      R_TLBIDX:  return 32'h8000_0000;
      R_CTXT:    return 32'hFF80_0000;
      R_TRAPWHY: return 32'hB000_F87C;
      R_CFGA:    return 32'h8017_FF80;
      R_DBGCTL:  return 32'h8C03_FC1F;
      default:   return '0;
    endcase
  endfunction

  // bits of a slot loaded from the write data
  function automatic word_t take_bits(int unsigned idx);
    case (idx)
      R_TLBIDX, 6:       return 32'h0000_000F;
      2, 3:              return 32'h3FFF_FFFF;
      R_CTXT:            return 32'h007F_FFF0;
      5:                 return 32'h01FF_E000;
      R_VPNHI:           return 32'hFFFF_E0FF;
      R_PSTAT:           return 32'hFA78_FF01;
      R_TRAPWHY:         return 32'h00C0_0300;
      14, 18, 24, 30, 31: return 32'hFFFF_FFFF;
      R_CFGA:            return 32'h7E00_0001;
      19:                return 32'h40FF_0FF8;
      R_DBGCTL:          return 32'h1330_0120;
      R_CTAG:            return 32'hFFFF_FCF6;
      default:           return '0;
    endcase
  endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode #(
  parameter int REG_AW = 5,
  parameter int SEL_W  = 3,
  localparam int NREG  = 1 << REG_AW
) (
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_reg,
  input  logic [SEL_W-1:0]  wr_sel,
  output logic [NREG-1:0]   slot_hit,
  output logic              legal_we,
  output logic              illegal_we
);
  import sysreg_pkg::*;

  logic multi_sel_reg;
  logic sel_zero;

  assign multi_sel_reg = (wr_reg == REG_AW'(R_CFGA)) || (wr_reg == REG_AW'(R_CTAG));
  assign sel_zero      = (wr_sel == '0);

  // only select 0 exists anywhere; registers with a select field reject the rest too
  always_comb begin
    if (sel_zero) begin
      legal_we   = wr_en;
      illegal_we = 1'b0;
    end else if (multi_sel_reg) begin
      legal_we   = 1'b0;
      illegal_we = wr_en;
    end else begin
      legal_we   = 1'b0;
      illegal_we = wr_en;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign slot_hit[i] = legal_we && (wr_reg == REG_AW'(i));
  end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int REG_AW = 5,
  localparam int NREG  = 1 << REG_AW,
  localparam int DW    = sysreg_pkg::DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREG-1:0]  slot_hit,
  input  logic [DW-1:0]    wr_data,
  output logic [NREG*DW-1:0] view
);
  import sysreg_pkg::*;

  logic [DW-1:0] q_arr [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam word_t HOLD = hold_bits(i);
    localparam word_t TAKE = take_bits(i);

    if ((HOLD | TAKE) != '0) begin : g_store
      always_ff @(posedge clk) begin
        if (rst) begin
          q_arr[i] <= '0;
        end else if (slot_hit[i]) begin
          q_arr[i] <= (q_arr[i] & HOLD) | (wr_data & TAKE);
        end
      end

      if (HOLD != '0) begin : g_hold_chk
        // hold bits survive any write to their slot
        p_hold_bits_r4: assert property (@(posedge clk) disable iff (rst)
          slot_hit[i] |=> ((q_arr[i] & HOLD) == $past(q_arr[i] & HOLD)));
      end
    end else begin : g_none
      assign q_arr[i] = '0;
    end

    assign view[i*DW +: DW] = q_arr[i];
  end

endmodule

// File: rtl/sysreg_mode_irq.sv
module sysreg_mode_irq #(
  localparam int DW = sysreg_pkg::DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pstat_we,
  input  logic          dbgctl_we,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] pstat_q,
  input  logic [DW-1:0] trapwhy_q,
  output logic          usr_q,
  output logic          exc_q,
  output logic          err_q,
  output logic          dbg_q,
  output logic          irq_q
);
  import sysreg_pkg::*;

  word_t new_pstat;
  logic  ien_rise;
  logic  ien_fall;
  logic  level_clear;
  logic  line_pending;

  assign new_pstat    = wr_data & take_bits(R_PSTAT);
  assign ien_rise     = new_pstat[ST_IEN] && !pstat_q[ST_IEN];
  assign ien_fall     = !new_pstat[ST_IEN] && pstat_q[ST_IEN];
  // levels come from this same write; debug mode from the current flag
  assign level_clear  = !wr_data[ST_EXC] && !wr_data[ST_ERR] && !dbg_q;
  assign line_pending = |(new_pstat & trapwhy_q & IRQ_LINE_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      usr_q <= 1'b0;
      exc_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (pstat_we) begin
      usr_q <= wr_data[ST_USR];
      exc_q <= wr_data[ST_EXC];
      err_q <= wr_data[ST_ERR];
      if (ien_rise && level_clear && line_pending) begin
        irq_q <= 1'b1;
      end else if (ien_fall) begin
        irq_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q <= 1'b0;
    end else if (dbgctl_we) begin
      dbg_q <= wr_data[DB_MODE];
    end
  end

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (pstat_we && !wr_data[ST_IEN] && pstat_q[ST_IEN]) |=> !irq_q);

  p_irq_rise_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(pstat_we));

endmodule

// File: rtl/sysreg_side.sv
module sysreg_side #(
  parameter int ASID_W = 8,
  localparam int DW    = sysreg_pkg::DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vpnhi_we,
  input  logic              ticks_we,
  input  logic              tmatch_we,
  input  logic              illegal_we,
  input  logic [DW-1:0]     wr_data,
  input  logic [ASID_W-1:0] asid_q,
  output logic              flush_q,
  output logic              ri_q,
  output logic              tmr_wr_q,
  output logic              tmr_cmp_q,
  output logic [DW-1:0]     tmr_data_q
);

  logic asid_moves;
  assign asid_moves = (wr_data[ASID_W-1:0] != asid_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q    <= 1'b0;
      ri_q       <= 1'b0;
      tmr_wr_q   <= 1'b0;
      tmr_cmp_q  <= 1'b0;
      tmr_data_q <= '0;
    end else begin
      flush_q  <= vpnhi_we && asid_moves;
      ri_q     <= illegal_we;
      tmr_wr_q <= ticks_we || tmatch_we;
      if (ticks_we || tmatch_we) begin
        tmr_cmp_q  <= tmatch_we;
        tmr_data_q <= wr_data;
      end
    end
  end

  p_flush_src_r5: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(vpnhi_we));

  p_tmr_src_r12: assert property (@(posedge clk) disable iff (rst)
    tmr_wr_q |-> $past(ticks_we || tmatch_we));

  p_ri_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    illegal_we |=> ri_q);

endmodule

// File: rtl/sysreg_wr_unit.sv
module sysreg_wr_unit #(
  parameter int REG_AW = 5,
  parameter int SEL_W  = 3,
  parameter int ASID_W = 8,
  localparam int NREG  = 1 << REG_AW,
  localparam int DW    = sysreg_pkg::DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_reg,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] reg_view_o,
  output logic               user_mode_o,
  output logic               exc_lvl_o,
  output logic               err_lvl_o,
  output logic               dbg_mode_o,
  output logic               hw_irq_o,
  output logic               tlb_flush_o,
  output logic               ri_exc_o,
  output logic               tmr_wr_o,
  output logic               tmr_is_cmp_o,
  output logic [DW-1:0]      tmr_data_o
);
  import sysreg_pkg::*;

  logic [NREG-1:0]    slot_hit;
  logic               legal_we;
  logic               illegal_we;
  logic [NREG*DW-1:0] flat;

  sysreg_decode #(.REG_AW(REG_AW), .SEL_W(SEL_W)) u_decode (
    .wr_en      (wr_en),
    .wr_reg     (wr_reg),
    .wr_sel     (wr_sel),
    .slot_hit   (slot_hit),
    .legal_we   (legal_we),
    .illegal_we (illegal_we)
  );

  sysreg_bank #(.REG_AW(REG_AW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .slot_hit (slot_hit),
    .wr_data  (wr_data),
    .view     (flat)
  );

  sysreg_mode_irq u_mode (
    .clk       (clk),
    .rst       (rst),
    .pstat_we  (slot_hit[R_PSTAT]),
    .dbgctl_we (slot_hit[R_DBGCTL]),
    .wr_data   (wr_data),
    .pstat_q   (flat[R_PSTAT*DW +: DW]),
    .trapwhy_q (flat[R_TRAPWHY*DW +: DW]),
    .usr_q     (user_mode_o),
    .exc_q     (exc_lvl_o),
    .err_q     (err_lvl_o),
    .dbg_q     (dbg_mode_o),
    .irq_q     (hw_irq_o)
  );

  sysreg_side #(.ASID_W(ASID_W)) u_side (
    .clk        (clk),
    .rst        (rst),
    .vpnhi_we   (slot_hit[R_VPNHI]),
    .ticks_we   (slot_hit[R_TICKS]),
    .tmatch_we  (slot_hit[R_TMATCH]),
    .illegal_we (illegal_we),
    .wr_data    (wr_data),
    .asid_q     (flat[R_VPNHI*DW +: ASID_W]),
    .flush_q    (tlb_flush_o),
    .ri_q       (ri_exc_o),
    .tmr_wr_q   (tmr_wr_o),
    .tmr_cmp_q  (tmr_is_cmp_o),
    .tmr_data_q (tmr_data_o)
  );

  assign reg_view_o = flat;

  p_illegal_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (!legal_we && wr_en) |=> (flat == $past(flat)));

  p_decode_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(legal_we && illegal_we));

endmodule

// File: tb/sysreg_wr_unit_tb.sv
module sysreg_wr_unit_tb;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_reg = '0;
  logic [2:0]    wr_sel = '0;
  logic [31:0]   wr_data = '0;
  logic [1023:0] reg_view_o;
  logic user_mode_o, exc_lvl_o, err_lvl_o, dbg_mode_o, hw_irq_o;
  logic tlb_flush_o, ri_exc_o, tmr_wr_o, tmr_is_cmp_o;
  logic [31:0] tmr_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysreg_wr_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel),
    .wr_data(wr_data), .reg_view_o(reg_view_o), .user_mode_o(user_mode_o),
    .exc_lvl_o(exc_lvl_o), .err_lvl_o(err_lvl_o), .dbg_mode_o(dbg_mode_o),
    .hw_irq_o(hw_irq_o), .tlb_flush_o(tlb_flush_o), .ri_exc_o(ri_exc_o),
    .tmr_wr_o(tmr_wr_o), .tmr_is_cmp_o(tmr_is_cmp_o), .tmr_data_o(tmr_data_o)
  );

  // {reg, sel, data, expected slot value, requirement number}
  localparam int NV = 26;
  localparam logic [75:0] VT [NV] = '{
    {5'd0,  3'd0, 32'hFFFF_FFFF, 32'h0000_000F, 4'd3},
    {5'd2,  3'd0, 32'hFFFF_FFFF, 32'h3FFF_FFFF, 4'd3},
    {5'd3,  3'd0, 32'hC000_0001, 32'h0000_0001, 4'd3},
    {5'd5,  3'd0, 32'hFFFF_FFFF, 32'h01FF_E000, 4'd3},
    {5'd6,  3'd0, 32'h1234_5678, 32'h0000_0008, 4'd3},
    {5'd19, 3'd0, 32'hFFFF_FFFF, 32'h40FF_0FF8, 4'd3},
    {5'd28, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FCF6, 4'd3},
    {5'd4,  3'd0, 32'hFFFF_FFFF, 32'h007F_FFF0, 4'd4},
    {5'd13, 3'd0, 32'hFFFF_FFFF, 32'h00C0_0300, 4'd4},
    {5'd16, 3'd0, 32'hFFFF_FFFF, 32'h7E00_0001, 4'd4},
    {5'd23, 3'd0, 32'hFFFF_FFFF, 32'h1330_0120, 4'd4},
    {5'd23, 3'd0, 32'h0000_0000, 32'h0000_0000, 4'd4},
    {5'd14, 3'd0, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 4'd11},
    {5'd18, 3'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd11},
    {5'd24, 3'd0, 32'h0123_4567, 32'h0123_4567, 4'd11},
    {5'd30, 3'd0, 32'h89AB_CDEF, 32'h89AB_CDEF, 4'd11},
    {5'd31, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd11},
    {5'd1,  3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10},
    {5'd15, 3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10},
    {5'd29, 3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10},
    {5'd22, 3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10},
    {5'd16, 3'd1, 32'h1234_5678, 32'h7E00_0001, 4'd2},
    {5'd28, 3'd3, 32'h0000_0000, 32'hFFFF_FCF6, 4'd2},
    {5'd0,  3'd2, 32'h0000_0000, 32'h0000_000F, 4'd2},
    {5'd9,  3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd12},
    {5'd11, 3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd12}
  };

  function automatic string rtag(int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(int r);
    return reg_view_o[r*32 +: 32];
  endfunction

  // strobe for one cycle; returns at the negedge after the capturing edge
  task automatic wr(logic [4:0] r, logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = r; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    for (int r = 0; r < 32; r++) chk("R1 reset slot", slot(r), 32'h0);
    chk("R1 reset flags", {27'h0, user_mode_o, exc_lvl_o, err_lvl_o, dbg_mode_o, hw_irq_o}, 32'h0);

    // not visible before the capturing edge
    @(negedge clk);
    wr_en = 1'b1; wr_reg = 5'd14; wr_sel = 3'd0; wr_data = 32'h1111_2222;
    #1 chk("R1 before edge", slot(14), 32'h0);
    @(negedge clk); wr_en = 1'b0;
    chk("R1 after edge", slot(14), 32'h1111_2222);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VT[i][75:71], VT[i][70:68], VT[i][67:36]);
      chk(rtag(int'(VT[i][3:0])), slot(int'(VT[i][75:71])), VT[i][35:4]);
      chk("R2 ri pulse", {31'h0, ri_exc_o}, {31'h0, VT[i][70:68] != 3'd0});
      if (VT[i][3:0] == 4'd12) begin
        chk("R12 tmr strobe", {31'h0, tmr_wr_o}, 32'h1);
        chk("R12 tmr kind", {31'h0, tmr_is_cmp_o}, {31'h0, VT[i][75:71] == 5'd11});
        chk("R12 tmr data", tmr_data_o, VT[i][67:36]);
      end
    end
    @(negedge clk);
    chk("R2 ri drops", {31'h0, ri_exc_o}, 32'h0);
    chk("R12 tmr drops", {31'h0, tmr_wr_o}, 32'h0);
    chk("R9 dbg after clear", {31'h0, dbg_mode_o}, 32'h0);

    // translation flush
    do_reset();
    wr(5'd10, 3'd0, 32'h0000_0012);
    chk("R5 flush on change", {31'h0, tlb_flush_o}, 32'h1);
    chk("R5 store", slot(10), 32'h0000_0012);
    @(negedge clk);
    chk("R5 flush one cycle", {31'h0, tlb_flush_o}, 32'h0);
    wr(5'd10, 3'd0, 32'hFFFF_E012);
    chk("R5 no flush same id", {31'h0, tlb_flush_o}, 32'h0);
    chk("R5 store hi", slot(10), 32'hFFFF_E012);
    wr(5'd10, 3'd0, 32'h0000_1F13);
    chk("R5 flush again", {31'h0, tlb_flush_o}, 32'h1);
    chk("R5 masked", slot(10), 32'h0000_0013);

    // mode flags
    wr(5'd12, 3'd0, 32'h0000_0016);
    chk("R6 flags set", {29'h0, user_mode_o, err_lvl_o, exc_lvl_o}, 32'h7);
    chk("R6 status masked", slot(12), 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0010);
    chk("R6 flags partial", {29'h0, user_mode_o, err_lvl_o, exc_lvl_o}, 32'h4);

    // interrupt request
    do_reset();
    wr(5'd13, 3'd0, 32'h0000_0300);
    wr(5'd12, 3'd0, 32'h0000_0300);
    chk("R7 no rise yet", {31'h0, hw_irq_o}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0301);
    chk("R7 raise", {31'h0, hw_irq_o}, 32'h1);
    wr(5'd12, 3'd0, 32'h0000_0301);
    chk("R8 hold while enabled", {31'h0, hw_irq_o}, 32'h1);
    wr(5'd12, 3'd0, 32'h0000_0300);
    chk("R8 drop", {31'h0, hw_irq_o}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0303);
    chk("R7 blocked by exc level", {31'h0, hw_irq_o}, 32'h0);
    chk("R6 exc level", {31'h0, exc_lvl_o}, 32'h1);
    wr(5'd12, 3'd0, 32'h0000_0300);
    wr(5'd12, 3'd0, 32'h0000_0305);
    chk("R7 blocked by err level", {31'h0, hw_irq_o}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0000);
    wr(5'd12, 3'd0, 32'h0000_0001);
    chk("R7 no line pending", {31'h0, hw_irq_o}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0000);
    wr(5'd23, 3'd0, 32'h4000_0000);
    chk("R9 dbg set", {31'h0, dbg_mode_o}, 32'h1);
    chk("R4 dbg bit not stored", slot(23), 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0301);
    chk("R7 blocked by debug", {31'h0, hw_irq_o}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0300);
    wr(5'd23, 3'd0, 32'h0000_0000);
    chk("R9 dbg clear", {31'h0, dbg_mode_o}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0301);
    chk("R7 raise again", {31'h0, hw_irq_o}, 32'h1);

    // reset clears everything
    do_reset();
    chk("R1 reset irq", {31'h0, hw_irq_o}, 32'h0);
    chk("R1 reset status", slot(12), 32'h0);
    chk("R1 reset cause", slot(13), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule